// File: doc/BRIEF.md
# Byte FIFO with Command Capture

This block is the byte queue that sits behind a storage controller's FIFO register. The host writes bytes and reads them back one at a time. A capture-mode input decides where each host write goes. While capture is active, the byte is appended to a separate command buffer and the command length grows by one. Otherwise the byte joins the data queue. The data queue reports an overrun one slot before it is physically full, so it never holds more than `DEPTH-1` bytes. A read returns the oldest queued byte only when the current bus phase is data-out. In any other phase the read gives zero, consumes the entry and raises a not-implemented error pulse.

Every host write also produces a one-cycle pulse that tells the surrounding status logic to drop its terminal-count flag. A flush input empties both buffers in a single cycle.

The command bytes can be read back through an indexed read port that has one cycle of latency. A downstream command decoder uses this port. The data RAM and the command RAM are plain dual-port arrays with registered reads, so block RAM can be inferred for them.

Top module: `byte_cmd_fifo`

## Requirements
- R1: After a synchronous reset, `fill_count`, `cmd_len`, `rd_data`, `ovr_err`, `pio_err` and `tc_clr` are all zero.
- R2: A write while `cap_mode` is 1 stores the byte at command index `cmd_len` and increments `cmd_len`, leaving the data queue untouched. `cmd_rd_data` shows the byte at `cmd_rd_idx` one cycle after the index is presented.
- R3: A capture write when `cmd_len` equals `DEPTH` is dropped, `cmd_len` holds, and `ovr_err` pulses high in the following cycle.
- R4: A data write (capture off) when `fill_count` equals `DEPTH-1` is rejected, the queue is unchanged, and `ovr_err` pulses high in the following cycle.
- R5: Any other data write appends the byte to the queue and raises `fill_count` by one.
- R6: A read with `fill_count` non-zero and `phase` equal to 2'b00 (data-out) puts the oldest byte on `rd_data` in the next cycle and lowers `fill_count` by one.
- R7: A read with `fill_count` non-zero and `phase` not equal to 2'b00 drives `rd_data` to 0 and pulses `pio_err` in the next cycle. The oldest entry is discarded and `fill_count` drops by one.
- R8: A read with `fill_count` zero changes neither `rd_data` nor `fill_count`, and it raises no error.
- R9: Every write strobe, accepted or not, pulses `tc_clr` in the next cycle.
- R10: `flush` clears `fill_count` and `cmd_len` in one cycle and overrides any read or write strobe in the same cycle.
- R11: Byte order is kept across any number of pointer wraps. The pointers wrap modulo `DEPTH` and return to zero whenever the queue drains.
- R12: A read and a data write in the same cycle with a non-empty, non-limit queue both take effect, and `fill_count` stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Host write byte |
| rd_en | input | 1 | Host read strobe |
| phase | input | 2 | Current bus phase; 2'b00 is data-out |
| cap_mode | input | 1 | Route writes to the command buffer |
| flush | input | 1 | Empty both buffers |
| cmd_rd_idx | input | log2(DEPTH) | Command buffer read index |
| rd_data | output | DW | Registered read byte |
| cmd_rd_data | output | DW | Registered command byte at `cmd_rd_idx` |
| cmd_len | output | log2(DEPTH)+1 | Number of captured command bytes |
| fill_count | output | log2(DEPTH)+1 | Bytes held in the data queue |
| ovr_err | output | 1 | Overrun pulse (data or command) |
| pio_err | output | 1 | Read in an unsupported phase pulse |
| tc_clr | output | 1 | Clear-terminal-count pulse |

## Verification
The bench fills the queue to `DEPTH-1` and writes once more. A design that checked against physical full would accept that byte and make the drain sequence one byte too long. It drains the queue in a phase other than data-out, which exposes a design that returns stale data or fails to discard the entry. Long streams that cross the wrap point, together with reads and writes issued in the same cycle, catch pointer slips and count drift. Flushes issued alongside strobes, and capture writes beyond `DEPTH`, expose strobes that leak past a flush and command lengths that wrap instead of holding.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
  typedef enum logic [1:0] {
    PH_DATA_OUT = 2'b00,
    PH_DATA_IN  = 2'b01,
    PH_COMMAND  = 2'b10,
    PH_STATUS   = 2'b11
  } phase_e;
endpackage

// File: rtl/bcf_ram.sv
module bcf_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bcf_data_ctl.sv
module bcf_data_ctl #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     wr_req,
  input  logic                     rd_req,
  input  logic                     phase_ok,
  output logic                     push,
  output logic                     ram_re,
  output logic [$clog2(DEPTH)-1:0] wptr,
  output logic [$clog2(DEPTH)-1:0] rptr,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     ovr,
  output logic                     pio,
  output logic                     zero_out
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic at_limit, pop;

  assign at_limit = (count == LIMIT);
  assign push     = wr_req & ~flush & ~at_limit;
  assign pop      = rd_req & ~flush & (count != '0);
  assign ram_re   = pop & phase_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      wptr     <= '0;
      rptr     <= '0;
      ovr      <= 1'b0;
      pio      <= 1'b0;
      zero_out <= 1'b1;
    end else begin
      ovr <= wr_req & ~flush & at_limit;
      pio <= pop & ~phase_ok;
      if (pop) zero_out <= ~phase_ok;
      if (flush) begin
        count <= '0;
        wptr  <= '0;
        rptr  <= '0;
      end else begin
        case ({push, pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
        if (pop && !push && count == CW'(1)) begin
          wptr <= '0;
          rptr <= '0;
        end else begin
          if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
          if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcf_cmd_ctl.sv
module bcf_cmd_ctl #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     cap_wr,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH):0]   len,
  output logic                     ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic room;

  assign room  = (len < CW'(DEPTH));
  assign we    = cap_wr & ~flush & room;
  assign waddr = len[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      len <= '0;
      ovr <= 1'b0;
    end else begin
      ovr <= cap_wr & ~flush & ~room;
      if (flush)   len <= '0;
      else if (we) len <= len + 1'b1;
    end
  end
endmodule

// File: rtl/byte_cmd_fifo.sv
module byte_cmd_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  input  logic [1:0]               phase,
  input  logic                     cap_mode,
  input  logic                     flush,
  input  logic [$clog2(DEPTH)-1:0] cmd_rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic [DW-1:0]            cmd_rd_data,
  output logic [$clog2(DEPTH):0]   cmd_len,
  output logic [$clog2(DEPTH):0]   fill_count,
  output logic                     ovr_err,
  output logic                     pio_err,
  output logic                     tc_clr
);
  import bcf_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic          phase_ok, d_push, d_re, d_ovr, d_zero, c_we, c_ovr;
  logic [AW-1:0] d_wptr, d_rptr, c_waddr;
  logic [DW-1:0] d_q;

  assign phase_ok = (phase_e'(phase) == PH_DATA_OUT);

  bcf_data_ctl #(.DEPTH(DEPTH)) data_ctl_i (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_req(wr_en & ~cap_mode), .rd_req(rd_en), .phase_ok(phase_ok),
    .push(d_push), .ram_re(d_re), .wptr(d_wptr), .rptr(d_rptr),
    .count(fill_count), .ovr(d_ovr), .pio(pio_err), .zero_out(d_zero)
  );

  bcf_ram #(.DW(DW), .DEPTH(DEPTH)) data_ram_i (
    .clk(clk), .we(d_push), .waddr(d_wptr), .wdata(wr_data),
    .re(d_re), .raddr(d_rptr), .rdata(d_q)
  );

  bcf_cmd_ctl #(.DEPTH(DEPTH)) cmd_ctl_i (
    .clk(clk), .rst(rst), .flush(flush), .cap_wr(wr_en & cap_mode),
    .we(c_we), .waddr(c_waddr), .len(cmd_len), .ovr(c_ovr)
  );

  bcf_ram #(.DW(DW), .DEPTH(DEPTH)) cmd_ram_i (
    .clk(clk), .we(c_we), .waddr(c_waddr), .wdata(wr_data),
    .re(1'b1), .raddr(cmd_rd_idx), .rdata(cmd_rd_data)
  );

  assign rd_data = d_zero ? '0 : d_q;
  assign ovr_err = d_ovr | c_ovr;

  always_ff @(posedge clk) begin
    if (rst) tc_clr <= 1'b0;
    else     tc_clr <= wr_en;
  end
endmodule

// File: rtl/bcf_checker.sv
module bcf_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [1:0]               phase,
  input logic                     cap_mode,
  input logic                     flush,
  input logic [DW-1:0]            rd_data,
  input logic [$clog2(DEPTH):0]   cmd_len,
  input logic [$clog2(DEPTH):0]   fill_count,
  input logic                     ovr_err,
  input logic                     pio_err,
  input logic                     tc_clr
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r4_count_limit: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CW'(DEPTH - 1));

  a_r4_reject_at_limit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cap_mode && !flush && !rd_en && fill_count == CW'(DEPTH - 1))
    |=> (ovr_err && fill_count == $past(fill_count)));

  a_r2_capture_grows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cap_mode && !flush && cmd_len < CW'(DEPTH))
    |=> (cmd_len == $past(cmd_len) + 1'b1));

  a_r7_wrong_phase: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !flush && fill_count != '0 && phase != 2'b00)
    |=> (pio_err && rd_data == '0));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !flush && fill_count == '0)
    |=> ($stable(rd_data) && !pio_err && fill_count == '0));

  a_r9_tc_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tc_clr);

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill_count == '0 && cmd_len == '0 && !ovr_err && !pio_err));
endmodule

bind byte_cmd_fifo bcf_checker #(.DW(DW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .phase(phase),
  .cap_mode(cap_mode), .flush(flush), .rd_data(rd_data), .cmd_len(cmd_len),
  .fill_count(fill_count), .ovr_err(ovr_err), .pio_err(pio_err), .tc_clr(tc_clr)
);

// File: tb/byte_cmd_fifo_tb_top.sv
`timescale 1ns/1ps
module byte_cmd_fifo_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, cap_mode = 1'b0, flush = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    phase = 2'b00;
  logic [AW-1:0] cmd_rd_idx = '0;
  logic [DW-1:0] rd_data, cmd_rd_data;
  logic [AW:0]   cmd_len, fill_count;
  logic          ovr_err, pio_err, tc_clr;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  byte unsigned q[$];
  int cmd_m[DEPTH];
  int clen = 0;
  int exp_rd = 0;

  always #2 clk = ~clk;

  byte_cmd_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .phase(phase), .cap_mode(cap_mode), .flush(flush), .cmd_rd_idx(cmd_rd_idx),
    .rd_data(rd_data), .cmd_rd_data(cmd_rd_data), .cmd_len(cmd_len),
    .fill_count(fill_count), .ovr_err(ovr_err), .pio_err(pio_err), .tc_clr(tc_clr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit w, input int d, input bit r,
                      input int ph, input bit cap, input bit fl, input int idx);
    int pre, e_ovr, e_pio, e_cmd;
    bit cmd_valid;
    @(negedge clk);
    wr_en = w; wr_data = DW'(d); rd_en = r; phase = 2'(ph);
    cap_mode = cap; flush = fl; cmd_rd_idx = AW'(idx);
    pre = q.size();
    cmd_valid = (idx < clen);
    e_cmd = cmd_m[idx];
    e_ovr = 0; e_pio = 0;
    if (fl) begin
      q.delete();
      clen = 0;
    end else begin
      if (r && pre > 0) begin
        int b;
        b = q.pop_front();
        if (ph == 0) exp_rd = b;
        else begin exp_rd = 0; e_pio = 1; end
      end
      if (w) begin
        if (cap) begin
          if (clen < DEPTH) begin cmd_m[clen] = d; clen++; end
          else e_ovr = 1;
        end else if (pre == DEPTH - 1) e_ovr = 1;
        else q.push_back(byte'(d));
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "fill_count", int'(fill_count), q.size());
    chk(tag, "cmd_len", int'(cmd_len), clen);
    chk(tag, "rd_data", int'(rd_data), exp_rd);
    chk(tag, "ovr_err", int'(ovr_err), e_ovr);
    chk(tag, "pio_err", int'(pio_err), e_pio);
    chk("R9", "tc_clr", int'(tc_clr), int'(w));
    if (cmd_valid) chk(tag, "cmd_rd_data", int'(cmd_rd_data), e_cmd);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    #1;
    chk("R1", "fill_count", int'(fill_count), 0);
    chk("R1", "cmd_len", int'(cmd_len), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    chk("R1", "ovr_err", int'(ovr_err), 0);
    chk("R1", "pio_err", int'(pio_err), 0);
    chk("R1", "tc_clr", int'(tc_clr), 0);

    // R5 / R6: simple write then read in data-out phase
    for (int i = 0; i < 5; i++) step("R5", 1, 8'h10 + i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R6", 0, 0, 1, 0, 0, 0, 0);
    // R8: read when empty
    step("R8", 0, 0, 1, 0, 0, 0, 0);
    step("R8", 0, 0, 1, 2, 0, 0, 0);

    // R4: fill to DEPTH-1 then overrun
    for (int i = 0; i < DEPTH - 1; i++) step("R5", 1, 8'hA0 + i, 0, 0, 0, 0, 0);
    step("R4", 1, 8'hEE, 0, 0, 0, 0, 0);
    step("R4", 1, 8'hEF, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step("R6", 0, 0, 1, 0, 0, 0, 0);

    // R2: capture mode, data queue untouched
    step("R5", 1, 8'h55, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R2", 1, 8'hC0 + i, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step("R2", 0, 0, 0, 0, 1, 0, i);
    step("R6", 0, 0, 1, 0, 0, 0, 0);
    // R3: capture to full and beyond
    for (int i = 4; i < DEPTH; i++) step("R2", 1, 8'h30 + i, 0, 0, 1, 0, i - 1);
    step("R3", 1, 8'hFF, 0, 0, 1, 0, DEPTH - 1);
    step("R3", 0, 0, 0, 0, 1, 0, DEPTH - 1);
    step("R3", 0, 0, 0, 0, 0, 0, 3);

    // R7: wrong-phase reads
    for (int i = 0; i < 3; i++) step("R5", 1, 8'h70 + i, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 1, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 3, 0, 0, 0);
    step("R8", 0, 0, 1, 0, 0, 0, 0);

    // R12: simultaneous read and write
    step("R5", 1, 8'h01, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R12", 1, 8'h80 + i, 1, 0, 0, 0, 0);
    step("R12", 1, 8'h90, 1, 0, 1, 0, 0);

    // R11: streams crossing the wrap point
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 11; i++) step("R11", 1, k * 16 + i, 0, 0, 0, 0, 0);
      for (int i = 0; i < 9; i++)  step("R11", 0, 0, 1, 0, 0, 0, 0);
    end
    while (q.size() > 0) step("R11", 0, 0, 1, 0, 0, 0, 0);

    // R10: flush overriding strobes
    for (int i = 0; i < 4; i++) step("R5", 1, 8'h40 + i, 0, 0, 0, 0, 0);
    step("R2", 1, 8'h99, 0, 0, 1, 0, 0);
    step("R10", 1, 8'h77, 1, 0, 0, 1, 0);
    step("R10", 0, 0, 1, 0, 0, 0, 0);
    step("R5", 1, 8'h42, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 0, 1, 1, 0);
    idle("R10");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int rv;
      rv = int'($urandom);
      step("R12", rv[0] | rv[1], rv[15:8], rv[2] & ~rv[9], (rv[3] & rv[4]) ? rv[6:5] : 0,
           rv[7] & rv[10] & rv[11], (rv[30:24] == 0), rv[19:16]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule